// File: doc/BRIEF.md
# Endpoint Interrupt Status Controller

This block gathers the service requests of the eight endpoints of a USB device controller into an 8-bit status register. It drives one level-sensitive interrupt line that stays high while any status bit is set. Software reads the status register to find which endpoints need service, then clears the bits it has handled by writing ones to them. A second 8-bit register holds one mask bit per endpoint. A set mask bit stops the matching status bit from ever being set. It does not gate the interrupt output.

Endpoint 0 raises its request when any of three things happens:
- its OUT-packet-ready flag rises,
- its IN-packet-ready flag falls,
- its sent-stall flag rises.

Endpoint 1 raises its request when its IN-transfer-done flag rises. Endpoints 2 to 7 each take a single-cycle event pulse. Endpoint flags are acted on at their edges, so a flag that stays at one level cannot set its bit again after software clears it.

Top module: `ep_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the status register and the mask register read 0 and `irq` is 0.
- R2: A write with `reg_sel`=0 clears every status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R3: While mask bit i (mask register bit i, `reg_sel`=1) is 1, no event sets status bit i. This holds for every mask value.
- R4: `irq` is 1 exactly when at least one status bit is 1, in the same cycle, and stays 1 until the last set bit is cleared.
- R5: A rising edge on `ep0_out_rdy` sets status bit 0 one clock later. A level that is held does not set the bit again after it is cleared.
- R6: A falling edge on `ep0_in_rdy` sets status bit 0. A rising edge on it does not.
- R7: A rising edge on `ep0_stall_sent` sets status bit 0.
- R8: A rising edge on `ep1_in_done` sets status bit 1.
- R9: A 1 on `ep_evt[k]` during a clock edge sets status bit k+2, for k = 0 to 5.
- R10: When an unmasked event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up 1.
- R11: Writing a mask bit to 1 leaves a status bit that is already set unchanged.
- R12: `rd_data` returns the status register for `reg_sel`=0 and the mask register for `reg_sel`=1, in bits 7:0. Bits 31:8 read 0, and the mask register reads back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 status, 1 mask |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data; status writes clear the bits that are 1 |
| rd_data | output | 32 | Read data of the selected register |
| ep0_out_rdy | input | 1 | Endpoint 0 OUT packet ready flag |
| ep0_in_rdy | input | 1 | Endpoint 0 IN packet ready flag |
| ep0_stall_sent | input | 1 | Endpoint 0 stall handshake sent flag |
| ep1_in_done | input | 1 | Endpoint 1 IN transfer complete flag |
| ep_evt | input | 6 | Event pulses for endpoints 2 to 7 |
| irq | output | 1 | Level interrupt request |

## Verification
Several properties are checked on every cycle. These are:
- `irq` matches the OR of the status bits.
- A masked bit never rises.
- A bit falls only after a write-1-to-clear to it.
- Every unmasked event lands, even when a clear hits the same bit.

Other behaviour can only be shown by the bench's scenarios. This covers the edge polarity of each endpoint 0 source, the absence of a repeat set while a flag is held, mask changes that leave a set bit alone, register readback, and the sweep over all 256 mask values.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  localparam int unsigned EP_COUNT = 8;
  localparam int unsigned BUS_W    = 32;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;

  // bit order of the endpoint 0 flag vector
  localparam int unsigned EP0_OUT_BIT   = 0;
  localparam int unsigned EP0_IN_BIT    = 1;
  localparam int unsigned EP0_STALL_BIT = 2;
endpackage

// File: rtl/ep_edge_det.sv
module ep_edge_det #(
  parameter int unsigned     W         = 1,
  parameter logic [W-1:0]    FALL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flag_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= flag_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (FALL_MASK[i]) begin : g_fall
      assign edge_o[i] = prev_q[i] & ~flag_i[i];
    end else begin : g_rise
      assign edge_o[i] = flag_i[i] & ~prev_q[i];
    end
  end
endmodule

// File: rtl/ep_evt_collect.sv
module ep_evt_collect #(
  parameter int unsigned NUM_EP = ep_irq_pkg::EP_COUNT,
  localparam int unsigned GEN_N = NUM_EP - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ep0_out_rdy,
  input  logic              ep0_in_rdy,
  input  logic              ep0_stall_sent,
  input  logic              ep1_in_done,
  input  logic [GEN_N-1:0]  gen_evt,
  output logic [NUM_EP-1:0] set_vec
);
  import ep_irq_pkg::*;

  logic [2:0] ep0_flags;
  logic [2:0] ep0_edges;
  logic       ep1_edge;

  always_comb begin
    ep0_flags                = '0;
    ep0_flags[EP0_OUT_BIT]   = ep0_out_rdy;
    ep0_flags[EP0_IN_BIT]    = ep0_in_rdy;
    ep0_flags[EP0_STALL_BIT] = ep0_stall_sent;
  end

  // IN-ready is watched for a falling edge, the other two for rising
  ep_edge_det #(.W(3), .FALL_MASK(3'(1 << EP0_IN_BIT))) u_ep0_edge (
    .clk    (clk),
    .rst    (rst),
    .flag_i (ep0_flags),
    .edge_o (ep0_edges)
  );

  ep_edge_det #(.W(1), .FALL_MASK(1'b0)) u_ep1_edge (
    .clk    (clk),
    .rst    (rst),
    .flag_i (ep1_in_done),
    .edge_o (ep1_edge)
  );

  assign set_vec = {gen_evt, ep1_edge, |ep0_edges};
endmodule

// File: rtl/ep_stat_reg.sv
module ep_stat_reg #(
  parameter int unsigned NUM_EP = ep_irq_pkg::EP_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              sel_mask,
  input  logic [NUM_EP-1:0] wr_bits,
  input  logic [NUM_EP-1:0] set_vec,
  output logic [NUM_EP-1:0] status_q,
  output logic [NUM_EP-1:0] mask_q,
  output logic              irq_q
);
  logic [NUM_EP-1:0] clr_vec;
  logic [NUM_EP-1:0] status_d;

  assign clr_vec  = (wr_en && !sel_mask) ? wr_bits : '0;
  // a set applied after the clear, so an event in a clearing cycle survives
  assign status_d = (status_q & ~clr_vec) | (set_vec & ~mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
      if (wr_en && sel_mask) mask_q <= wr_bits;
    end
  end
endmodule

// File: rtl/ep_irq_ctrl.sv
module ep_irq_ctrl #(
  parameter int unsigned NUM_EP = ep_irq_pkg::EP_COUNT,
  parameter int unsigned DATA_W = ep_irq_pkg::BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ep0_out_rdy,
  input  logic              ep0_in_rdy,
  input  logic              ep0_stall_sent,
  input  logic              ep1_in_done,
  input  logic [NUM_EP-3:0] ep_evt,
  output logic              irq
);
  import ep_irq_pkg::*;

  localparam int unsigned PAD_W = DATA_W - NUM_EP;

  logic [NUM_EP-1:0] set_vec;
  logic [NUM_EP-1:0] status_q;
  logic [NUM_EP-1:0] mask_q;
  logic              sel_mask;

  assign sel_mask = (reg_sel_e'(reg_sel) == SEL_MASK);

  ep_evt_collect #(.NUM_EP(NUM_EP)) u_collect (
    .clk            (clk),
    .rst            (rst),
    .ep0_out_rdy    (ep0_out_rdy),
    .ep0_in_rdy     (ep0_in_rdy),
    .ep0_stall_sent (ep0_stall_sent),
    .ep1_in_done    (ep1_in_done),
    .gen_evt        (ep_evt),
    .set_vec        (set_vec)
  );

  ep_stat_reg #(.NUM_EP(NUM_EP)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .sel_mask (sel_mask),
    .wr_bits  (wr_data[NUM_EP-1:0]),
    .set_vec  (set_vec),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_q    (irq)
  );

  assign rd_data = {{PAD_W{1'b0}}, (sel_mask ? mask_q : status_q)};
endmodule

// File: rtl/ep_irq_ctrl_chk.sv
module ep_irq_ctrl_chk #(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_sel,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_EP-1:0] set_vec,
  input logic [NUM_EP-1:0] status_q,
  input logic [NUM_EP-1:0] mask_q,
  input logic              irq
);
  logic [NUM_EP-1:0] wr_clr;
  assign wr_clr = (wr_en && !reg_sel) ? wr_data[NUM_EP-1:0] : '0;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '0 && !irq)); // R1

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(status_q) & ~status_q & ~$past(wr_clr)) == '0)); // R2

  AST_MASKED_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & ~$past(status_q) & $past(mask_q)) == '0)); // R3

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    irq == (status_q != '0)); // R4

  AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(set_vec & ~mask_q) & ~status_q) == '0)); // R10

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-1:NUM_EP] == '0); // R12
endmodule

bind ep_irq_ctrl ep_irq_ctrl_chk #(.NUM_EP(NUM_EP), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_sel  (reg_sel),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .set_vec  (set_vec),
  .status_q (status_q),
  .mask_q   (mask_q),
  .irq      (irq)
);

// File: tb/tb_ep_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ep_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ep0_out_rdy = 1'b0;
  logic        ep0_in_rdy = 1'b0;
  logic        ep0_stall_sent = 1'b0;
  logic        ep1_in_done = 1'b0;
  logic [5:0]  ep_evt = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ep_irq_ctrl dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ep0_out_rdy(ep0_out_rdy), .ep0_in_rdy(ep0_in_rdy),
    .ep0_stall_sent(ep0_stall_sent), .ep1_in_done(ep1_in_done),
    .ep_evt(ep_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic read_chk(input string req, input logic sel, input logic [31:0] exp);
    reg_sel = sel;
    #1;
    chk(req, rd_data, exp);
    reg_sel = 1'b0;
  endtask

  task automatic write_reg(input logic sel, input logic [31:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0; wr_data = '0; reg_sel = 1'b0;
  endtask

  task automatic pulse_gen(input logic [5:0] v);
    ep_evt = v;
    step();
    ep_evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    read_chk("R1 status", 1'b0, 32'h0);
    read_chk("R1 mask", 1'b1, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R12 mask readback with upper bits dropped
    write_reg(1'b1, 32'hFFFF_FFA5);
    read_chk("R12 mask readback", 1'b1, 32'h0000_00A5);
    write_reg(1'b1, 32'h0);

    // R5 out-ready rising edge, then held level
    ep0_out_rdy = 1'b1;
    step();
    read_chk("R5 out rise", 1'b0, 32'h01);
    chk("R4 irq set", {31'b0, irq}, 32'h1);
    write_reg(1'b0, 32'h01);
    step();
    read_chk("R5 held no reset", 1'b0, 32'h00);
    chk("R4 irq clear", {31'b0, irq}, 32'h0);
    ep0_out_rdy = 1'b0;
    step();
    read_chk("R5 fall ignored", 1'b0, 32'h00);

    // R6 in-ready: rise ignored, fall sets
    ep0_in_rdy = 1'b1;
    step(); step();
    read_chk("R6 in rise ignored", 1'b0, 32'h00);
    ep0_in_rdy = 1'b0;
    step();
    read_chk("R6 in fall", 1'b0, 32'h01);
    write_reg(1'b0, 32'h01);

    // R7 stall rising edge
    ep0_stall_sent = 1'b1;
    step();
    read_chk("R7 stall rise", 1'b0, 32'h01);
    ep0_stall_sent = 1'b0;
    write_reg(1'b0, 32'h01);

    // R8 endpoint 1
    ep1_in_done = 1'b1;
    step();
    read_chk("R8 ep1 rise", 1'b0, 32'h02);
    ep1_in_done = 1'b0;
    write_reg(1'b0, 32'h02);
    read_chk("R8 ep1 cleared", 1'b0, 32'h00);

    // R9 each generic source alone
    for (int k = 0; k < 6; k++) begin
      pulse_gen(6'(1 << k));
      read_chk("R9 generic", 1'b0, 32'(1 << (k + 2)));
      write_reg(1'b0, 32'hFF);
    end

    // R2 partial clear and zero write; R4 irq holds until last bit
    pulse_gen(6'h3F);
    read_chk("R2 all generic set", 1'b0, 32'hFC);
    write_reg(1'b0, 32'h0C);
    read_chk("R2 partial clear", 1'b0, 32'hF0);
    write_reg(1'b0, 32'h00);
    read_chk("R2 zero write keeps", 1'b0, 32'hF0);
    for (int b = 4; b < 8; b++) begin
      chk("R4 irq before clear", {31'b0, irq}, 32'h1);
      write_reg(1'b0, 32'(1 << b));
    end
    chk("R4 irq after last", {31'b0, irq}, 32'h0);

    // R10 set wins over clear on the same bit
    pulse_gen(6'h01);
    ep_evt = 6'h01; reg_sel = 1'b0; wr_data = 32'h04; wr_en = 1'b1;
    step();
    ep_evt = '0; wr_en = 1'b0; wr_data = '0;
    read_chk("R10 set wins", 1'b0, 32'h04);
    write_reg(1'b0, 32'h04);

    // R11 mask after set keeps bit; then masked pulse ignored
    pulse_gen(6'h02);
    write_reg(1'b1, 32'h08);
    read_chk("R11 mask keeps set", 1'b0, 32'h08);
    write_reg(1'b0, 32'h08);
    pulse_gen(6'h02);
    read_chk("R3 masked pulse", 1'b0, 32'h00);

    // R3 exhaustive mask sweep, all sources fire together
    for (int m = 0; m < 256; m++) begin
      write_reg(1'b1, 32'(m));
      write_reg(1'b0, 32'hFF);
      ep0_out_rdy = 1'b1; ep1_in_done = 1'b1; ep_evt = 6'h3F;
      step();
      ep0_out_rdy = 1'b0; ep1_in_done = 1'b0; ep_evt = '0;
      read_chk("R3 sweep status", 1'b0, 32'(~m & 8'hFF));
      chk("R3 sweep irq", {31'b0, irq}, {31'b0, (m != 255)});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule